// File: doc/BRIEF.md
# Criticality-Steered Intercluster Transfer Scheduler

This block sits between one processor cluster and a link to the other clusters. The link is made of three kinds of wire. The fast class is narrow and carries one 10-bit value per cycle. The baseline class carries one 64-bit value per cycle. The low-power class is slow and wide and carries two 64-bit values per cycle. Up to two transfer requests arrive each cycle, one per lane, and lane 0 is the older of the two. Each request has a kind, a payload, a destination cluster and the index of the producing instruction's PC.

The block chooses a wire class for each request from its kind. Register operands that are ready at dispatch and store data are not critical, so they take the low-power class. Low-order effective-address bits take the fast class. Produced results use a table of 2-bit saturating counters, indexed by PC, to guess whether the value fits in 10 bits. A result guessed narrow takes the fast class and any other result takes the baseline class. When a result guessed narrow turns out to be wide, the low bits still leave on the fast class, a full copy is queued on the baseline class, and a mispredict flag is raised. Each class has a small in-order queue and a fixed-latency pipeline. The default latencies are 1, 2 and 3 cycles. A ring setting of 2, 4 and 6 cycles is chosen by parameters.

Top module: `lk_steer`

## Requirements
- R1: Kind 0 (operand ready at dispatch) and kind 1 (store data) are delivered only on the low-power outputs, with kind, destination and the full 64-bit payload unchanged.
- R2: Kind 3 (early address bits) is delivered only on the fast output, carrying payload bits [9:0].
- R3: Kind 2 (result) goes to the fast output when the counter at its PC index is 2 or 3 at acceptance. Otherwise it goes to the baseline output with the full payload.
- R4: Each counter resets to 0. Every accepted result moves its counter by one, up when payload bits [63:10] are all zero and down otherwise, and the counter saturates at 0 and 3. Both lanes read the counters as they were before the cycle's updates, and lane 0's update is applied before lane 1's.
- R5: A result sent on the fast class whose payload has a nonzero bit in [63:10] is also delivered on the baseline output with its full payload. mispredict[j] is high for exactly the one cycle after lane j was accepted.
- R6: Per cycle the fast and baseline outputs each deliver at most one transfer and the low-power outputs deliver at most two.
- R7: Within a class, transfers leave in order of acceptance, with lane 0 ahead of lane 1 in the same cycle. A transfer that finds its class full waits for it and never changes class. On the low-power pair the older transfer uses slot 0.
- R8: A request accepted in cycle t to an uncontended class appears on that class's output in cycle t+L. L is LAT_FAST, LAT_BASE or LAT_LP (1, 2 and 3 by default).
- R9: in_ready is high exactly when every class queue has at least two free entries. While it is low, requests have no effect on any output or on the predictor.
- R10: After reset every output valid and mispredict is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request present, per lane |
| req_kind | input | 2x2 | Request kind per lane (0 operand, 1 store, 2 result, 3 address bits) |
| req_data | input | 2x64 | Payload per lane |
| req_dest | input | 2xDSTW | Destination cluster per lane |
| req_pc | input | 2xIW | Predictor index per lane |
| in_ready | output | 1 | Requests are accepted this cycle |
| fast_valid | output | 1 | Fast class delivery |
| fast_kind | output | 2 | Kind of fast delivery |
| fast_dest | output | DSTW | Destination of fast delivery |
| fast_data | output | 10 | Low payload bits of fast delivery |
| base_valid | output | 1 | Baseline class delivery |
| base_kind | output | 2 | Kind of baseline delivery |
| base_dest | output | DSTW | Destination of baseline delivery |
| base_data | output | 64 | Baseline payload |
| lp_valid | output | 2 | Low-power deliveries, slot 0 older |
| lp_kind | output | 2x2 | Kind per low-power slot |
| lp_dest | output | 2xDSTW | Destination per low-power slot |
| lp_data | output | 2x64 | Payload per low-power slot |
| mispredict | output | 2 | Narrow guess proved wrong, per lane |

## Verification
The bench trains one counter up to saturation and then sends wide values. A design with a wrong threshold or no saturation would route the following results to the other class, or would drop or duplicate the baseline copy and its flag. Pairs of address requests fill the fast queue. A design that ignored the one-per-cycle width would deliver two at once, and one that spilled waiting requests to another class or reordered the lanes would show the payloads in the wrong place or order. Requests offered while in_ready is low must leave no trace, and a design that took them anyway would show extra deliveries or counters that moved.

// File: rtl/lk_pkg.sv
package lk_pkg;
    localparam int NLANE    = 2;
    localparam int DW       = 64;
    localparam int NARROW_W = 10;

    typedef enum logic [1:0] {
        K_OPND   = 2'd0,
        K_STORE  = 2'd1,
        K_RESULT = 2'd2,
        K_ADDR   = 2'd3
    } kind_e;
endpackage

// File: rtl/lk_narrow_pred.sv
module lk_narrow_pred #(
    parameter int IW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          upd_v,
    input  logic [1:0][IW-1:0]  idx,
    input  logic [1:0]          narrow,
    output logic [1:0]          pred
);
    localparam int NE = 1 << IW;

    typedef struct packed {
        logic [NE-1:0][1:0] ctr;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        for (int j = 0; j < 2; j++) begin
            // prediction sees the table before this cycle's updates
            pred[j] = s_q.ctr[idx[j]][1];
            if (upd_v[j]) begin
                if (narrow[j] && s_d.ctr[idx[j]] != 2'b11)
                    s_d.ctr[idx[j]] = s_d.ctr[idx[j]] + 2'd1;
                else if (!narrow[j] && s_d.ctr[idx[j]] != 2'b00)
                    s_d.ctr[idx[j]] = s_d.ctr[idx[j]] - 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/lk_class_q.sv
module lk_class_q #(
    parameter int EW    = 68,
    parameter int CAP   = 1,
    parameter int DEPTH = 4,
    parameter int LAT   = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              in_v,
    input  logic [1:0][EW-1:0]      in_e,
    output logic [CAP-1:0]          out_v,
    output logic [CAP-1:0][EW-1:0]  out_e,
    output logic                    room
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = DEPTH + 2;

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0]        q;
        logic [CW-1:0]                   cnt;
        logic [LAT-1:0][CAP-1:0]         sv;
        logic [LAT-1:0][CAP-1:0][EW-1:0] se;
    } st_t;

    st_t s_q, s_d;
    logic [AW-1:0][EW-1:0] all;

    always_comb begin
        int n;
        s_d = s_q;
        all = '0;
        n   = 0;
        // queued entries first (older), then this cycle's lanes in order
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(s_q.cnt)) begin
                all[n] = s_q.q[i];
                n++;
            end
        end
        for (int j = 0; j < 2; j++) begin
            if (in_v[j]) begin
                all[n] = in_e[j];
                n++;
            end
        end
        for (int i = LAT - 1; i > 0; i--) begin
            s_d.sv[i] = s_q.sv[i-1];
            s_d.se[i] = s_q.se[i-1];
        end
        for (int k = 0; k < CAP; k++) begin
            s_d.sv[0][k] = (k < n);
            s_d.se[0][k] = (k < n) ? all[k] : '0;
        end
        s_d.q = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i + CAP < n) s_d.q[i] = all[i+CAP];
        end
        s_d.cnt = (n > CAP) ? CW'(n - CAP) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_v = s_q.sv[LAT-1];
    assign out_e = s_q.se[LAT-1];
    assign room  = (int'(s_q.cnt) <= DEPTH - 2);
endmodule

// File: rtl/lk_steer.sv
module lk_steer
    import lk_pkg::*;
#(
    parameter int NCLU     = 4,
    parameter int IW       = 6,
    parameter int QDEPTH   = 4,
    parameter int LAT_FAST = 1,
    parameter int LAT_BASE = 2,
    parameter int LAT_LP   = 3,
    parameter int DSTW     = $clog2(NCLU)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               req_valid,
    input  logic [1:0][1:0]          req_kind,
    input  logic [1:0][DW-1:0]       req_data,
    input  logic [1:0][DSTW-1:0]     req_dest,
    input  logic [1:0][IW-1:0]       req_pc,
    output logic                     in_ready,
    output logic                     fast_valid,
    output logic [1:0]               fast_kind,
    output logic [DSTW-1:0]          fast_dest,
    output logic [NARROW_W-1:0]      fast_data,
    output logic                     base_valid,
    output logic [1:0]               base_kind,
    output logic [DSTW-1:0]          base_dest,
    output logic [DW-1:0]            base_data,
    output logic [1:0]               lp_valid,
    output logic [1:0][1:0]          lp_kind,
    output logic [1:0][DSTW-1:0]     lp_dest,
    output logic [1:0][DW-1:0]       lp_data,
    output logic [1:0]               mispredict
);
    localparam int EW  = 2 + DSTW + DW;
    localparam int EWF = 2 + DSTW + NARROW_W;

    typedef struct packed {
        logic [1:0] misp;
    } st_t;

    st_t s_q, s_d;

    logic [1:0]           acc, narrow, is_res, pred;
    logic [1:0]           f_v, b_v, l_v;
    logic [1:0][EW-1:0]   ent;
    logic [1:0][EWF-1:0]  ent_f;
    logic                 room_f, room_b, room_l;
    logic [0:0][EWF-1:0]  out_f;
    logic [0:0][EW-1:0]   out_b;
    logic [1:0][EW-1:0]   out_l;

    assign in_ready = room_f & room_b & room_l;

    always_comb begin
        s_d = s_q;
        for (int j = 0; j < 2; j++) begin
            acc[j]    = req_valid[j] & in_ready;
            narrow[j] = ~|req_data[j][DW-1:NARROW_W];
            ent[j]    = {req_kind[j], req_dest[j], req_data[j]};
            ent_f[j]  = {req_kind[j], req_dest[j], req_data[j][NARROW_W-1:0]};
            is_res[j] = acc[j] && (req_kind[j] == K_RESULT);
            f_v[j] = 1'b0;
            b_v[j] = 1'b0;
            l_v[j] = 1'b0;
            if (acc[j]) begin
                unique case (req_kind[j])
                    K_OPND, K_STORE: l_v[j] = 1'b1;
                    K_ADDR:          f_v[j] = 1'b1;
                    default: begin
                        f_v[j] = pred[j];
                        b_v[j] = !pred[j] || !narrow[j];
                    end
                endcase
            end
            s_d.misp[j] = is_res[j] && pred[j] && !narrow[j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mispredict = s_q.misp;

    lk_narrow_pred #(.IW(IW)) u_pred (
        .clk(clk), .rst_n(rst_n), .upd_v(is_res), .idx(req_pc),
        .narrow(narrow), .pred(pred)
    );

    lk_class_q #(.EW(EWF), .CAP(1), .DEPTH(QDEPTH), .LAT(LAT_FAST)) u_fast (
        .clk(clk), .rst_n(rst_n), .in_v(f_v), .in_e(ent_f),
        .out_v(fast_valid), .out_e(out_f), .room(room_f)
    );

    lk_class_q #(.EW(EW), .CAP(1), .DEPTH(QDEPTH), .LAT(LAT_BASE)) u_base (
        .clk(clk), .rst_n(rst_n), .in_v(b_v), .in_e(ent),
        .out_v(base_valid), .out_e(out_b), .room(room_b)
    );

    lk_class_q #(.EW(EW), .CAP(2), .DEPTH(QDEPTH), .LAT(LAT_LP)) u_lp (
        .clk(clk), .rst_n(rst_n), .in_v(l_v), .in_e(ent),
        .out_v(lp_valid), .out_e(out_l), .room(room_l)
    );

    assign fast_kind = out_f[0][EWF-1 -: 2];
    assign fast_dest = out_f[0][NARROW_W +: DSTW];
    assign fast_data = out_f[0][NARROW_W-1:0];
    assign base_kind = out_b[0][EW-1 -: 2];
    assign base_dest = out_b[0][DW +: DSTW];
    assign base_data = out_b[0][DW-1:0];

    for (genvar k = 0; k < 2; k++) begin : g_lp
        assign lp_kind[k] = out_l[k][EW-1 -: 2];
        assign lp_dest[k] = out_l[k][DW +: DSTW];
        assign lp_data[k] = out_l[k][DW-1:0];
    end
endmodule

// File: rtl/lk_steer_chk.sv
module lk_steer_chk
    import lk_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          req_valid,
    input logic [1:0][1:0]     req_kind,
    input logic [1:0][DW-1:0]  req_data,
    input logic                in_ready,
    input logic                fast_valid,
    input logic [1:0]          fast_kind,
    input logic                base_valid,
    input logic [1:0]          base_kind,
    input logic [1:0]          lp_valid,
    input logic [1:0][1:0]     lp_kind,
    input logic [1:0]          mispredict
);
    // R1: low-power slots carry only operand or store traffic
    a_r1_lp0_kind: assert property (@(posedge clk) disable iff (!rst_n)
        lp_valid[0] |-> (lp_kind[0] == K_OPND || lp_kind[0] == K_STORE));
    a_r1_lp1_kind: assert property (@(posedge clk) disable iff (!rst_n)
        lp_valid[1] |-> (lp_kind[1] == K_OPND || lp_kind[1] == K_STORE));
    // R2: fast class carries only results and address bits
    a_r2_fast_kind: assert property (@(posedge clk) disable iff (!rst_n)
        fast_valid |-> (fast_kind == K_RESULT || fast_kind == K_ADDR));
    // R3: baseline class carries only results
    a_r3_base_kind: assert property (@(posedge clk) disable iff (!rst_n)
        base_valid |-> (base_kind == K_RESULT));
    // R7: a lone low-power delivery sits in slot 0
    a_r7_lp_order: assert property (@(posedge clk) disable iff (!rst_n)
        lp_valid[1] |-> lp_valid[0]);
    // R5: a flag needs an accepted wide result on that lane one cycle earlier
    a_r5_misp_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict[0] |-> $past(req_valid[0] && in_ready && req_kind[0] == K_RESULT
                                && (|req_data[0][DW-1:NARROW_W])));
    a_r5_misp_lane1: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict[1] |-> $past(req_valid[1] && in_ready && req_kind[1] == K_RESULT
                                && (|req_data[1][DW-1:NARROW_W])));
endmodule

bind lk_steer lk_steer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_data(req_data), .in_ready(in_ready), .fast_valid(fast_valid),
    .fast_kind(fast_kind), .base_valid(base_valid), .base_kind(base_kind),
    .lp_valid(lp_valid), .lp_kind(lp_kind), .mispredict(mispredict)
);

// File: tb/sim_lk_steer.sv
`timescale 1ns/1ps
module sim_lk_steer;
    import lk_pkg::*;

    localparam int DSTW = 2, IW = 6, QD = 4, LF = 1, LB = 2, LL = 3;
    localparam int EW = 2 + DSTW + 64;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic [1:0] req_valid;
    logic [1:0][1:0] req_kind;
    logic [1:0][63:0] req_data;
    logic [1:0][DSTW-1:0] req_dest;
    logic [1:0][IW-1:0] req_pc;
    logic in_ready, fast_valid, base_valid;
    logic [1:0] fast_kind, base_kind, lp_valid, mispredict;
    logic [DSTW-1:0] fast_dest, base_dest;
    logic [9:0] fast_data;
    logic [63:0] base_data;
    logic [1:0][1:0] lp_kind;
    logic [1:0][DSTW-1:0] lp_dest;
    logic [1:0][63:0] lp_data;

    lk_steer #(.NCLU(4), .IW(IW), .QDEPTH(QD), .LAT_FAST(LF), .LAT_BASE(LB), .LAT_LP(LL)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_data(req_data), .req_dest(req_dest), .req_pc(req_pc), .in_ready(in_ready),
        .fast_valid(fast_valid), .fast_kind(fast_kind), .fast_dest(fast_dest), .fast_data(fast_data),
        .base_valid(base_valid), .base_kind(base_kind), .base_dest(base_dest), .base_data(base_data),
        .lp_valid(lp_valid), .lp_kind(lp_kind), .lp_dest(lp_dest), .lp_data(lp_data),
        .mispredict(mispredict)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    bit [1:0] ctr [64];
    logic [EW-1:0] mq_f[$], mq_b[$], mq_l[$];
    string tq_f[$], tq_b[$], tq_l[$];
    bit ef_v[8], eb_v[8];
    bit el_v[8][2];
    logic [EW-1:0] ef_e[8], eb_e[8];
    logic [EW-1:0] el_e[8][2];
    string ef_t[8], eb_t[8];
    string el_t[8][2];
    logic [1:0] em[8];

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d act=%h exp=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic bit model_ready();
        return mq_f.size() <= QD - 2 && mq_b.size() <= QD - 2 && mq_l.size() <= QD - 2;
    endfunction

    task automatic check_outputs();
        int s = cyc % 8;
        chk(in_ready == model_ready(), "R9", 128'(in_ready), 128'(model_ready()));
        chk(fast_valid == ef_v[s] && (!ef_v[s] ||
            {fast_kind, fast_dest, fast_data} == {ef_e[s][EW-1:64], ef_e[s][9:0]}),
            ef_v[s] ? ef_t[s] : "R6", {fast_valid, fast_kind, fast_dest, fast_data},
            {ef_v[s], ef_e[s][EW-1:64], ef_e[s][9:0]});
        chk(base_valid == eb_v[s] && (!eb_v[s] || {base_kind, base_dest, base_data} == eb_e[s]),
            eb_v[s] ? eb_t[s] : "R6", {base_valid, base_kind, base_dest, base_data},
            {eb_v[s], eb_e[s]});
        for (int k = 0; k < 2; k++)
            chk(lp_valid[k] == el_v[s][k] && (!el_v[s][k] ||
                {lp_kind[k], lp_dest[k], lp_data[k]} == el_e[s][k]),
                el_v[s][k] ? el_t[s][k] : "R6", {lp_valid[k], lp_kind[k], lp_dest[k], lp_data[k]},
                {el_v[s][k], el_e[s][k]});
        chk(mispredict == em[s], "R5", 128'(mispredict), 128'(em[s]));
        ef_v[s] = 0; eb_v[s] = 0; el_v[s][0] = 0; el_v[s][1] = 0; em[s] = 0;
    endtask

    task automatic model(string ov);
        bit [1:0] p;
        if (model_ready()) begin
            for (int j = 0; j < 2; j++) p[j] = ctr[req_pc[j]][1];
            for (int j = 0; j < 2; j++) begin
                if (req_valid[j]) begin
                    logic [EW-1:0] e = {req_kind[j], req_dest[j], req_data[j]};
                    bit nar = (req_data[j][63:10] == 0);
                    case (req_kind[j])
                        2'd0, 2'd1: begin mq_l.push_back(e); tq_l.push_back(ov != "" ? ov : "R1"); end
                        2'd3: begin mq_f.push_back(e); tq_f.push_back(ov != "" ? ov : "R2"); end
                        default: begin
                            if (p[j]) begin mq_f.push_back(e); tq_f.push_back(ov != "" ? ov : "R3"); end
                            if (!p[j] || !nar) begin
                                mq_b.push_back(e);
                                tq_b.push_back(ov != "" ? ov : (p[j] ? "R5" : "R3"));
                            end
                            if (p[j] && !nar) em[(cyc + 1) % 8][j] = 1'b1;
                            if (nar && ctr[req_pc[j]] != 2'd3) ctr[req_pc[j]]++;
                            else if (!nar && ctr[req_pc[j]] != 2'd0) ctr[req_pc[j]]--;
                        end
                    endcase
                end
            end
        end
        if (mq_f.size() > 0) begin
            ef_v[(cyc + LF) % 8] = 1; ef_e[(cyc + LF) % 8] = mq_f.pop_front();
            ef_t[(cyc + LF) % 8] = tq_f.pop_front();
        end
        if (mq_b.size() > 0) begin
            eb_v[(cyc + LB) % 8] = 1; eb_e[(cyc + LB) % 8] = mq_b.pop_front();
            eb_t[(cyc + LB) % 8] = tq_b.pop_front();
        end
        for (int k = 0; k < 2; k++)
            if (mq_l.size() > 0) begin
                el_v[(cyc + LL) % 8][k] = 1; el_e[(cyc + LL) % 8][k] = mq_l.pop_front();
                el_t[(cyc + LL) % 8][k] = tq_l.pop_front();
            end
    endtask

    task automatic step(string ov);
        check_outputs();
        model(ov);
        @(posedge clk);
        cyc++;
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic put(int j, logic [1:0] k, logic [63:0] d, logic [DSTW-1:0] ds, logic [IW-1:0] pc);
        req_valid[j] = 1'b1; req_kind[j] = k; req_data[j] = d; req_dest[j] = ds; req_pc[j] = pc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R10 act=running exp=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 64; i++) ctr[i] = 0;
        for (int i = 0; i < 8; i++) begin
            ef_v[i] = 0; eb_v[i] = 0; el_v[i][0] = 0; el_v[i][1] = 0; em[i] = 0;
        end
        rst_n = 0; req_valid = '0; req_kind = '0; req_data = '0; req_dest = '0; req_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: idle outputs and open input after reset
        chk({fast_valid, base_valid, lp_valid, mispredict} == 0, "R10",
            128'({fast_valid, base_valid, lp_valid, mispredict}), 128'(0));
        chk(in_ready == 1'b1, "R10", 128'(in_ready), 128'(1));
        rst_n = 1;
        @(negedge clk);

        // R8: lone transfers on each class with nothing queued
        put(0, 2'd1, 64'hDEAD_BEEF_0123_4567, 2'd2, 6'd1); step("R8");
        repeat (4) step("");
        put(0, 2'd3, 64'h3A5, 2'd1, 6'd1); step("R8");
        repeat (4) step("");
        put(1, 2'd2, 64'h1234_5678, 2'd3, 6'd9); step("R8");
        repeat (4) step("");

        // R4: train one counter, saturate it, then walk it down with wide values
        for (int i = 0; i < 6; i++) begin put(0, 2'd2, 64'(i * 7), 2'd0, 6'd7); step("R4"); end
        for (int i = 0; i < 4; i++) begin put(0, 2'd2, 64'hF000 + 64'(i), 2'd1, 6'd7); step("R4"); end
        put(0, 2'd2, 64'h5, 2'd1, 6'd7); put(1, 2'd2, 64'h10_0000, 2'd2, 6'd7); step("R4");
        repeat (6) step("");

        // R7 and R6: both lanes on the fast class until the queue pushes back
        for (int i = 0; i < 4; i++) begin
            put(0, 2'd3, 64'(16 * i), 2'd0, 6'd0); put(1, 2'd3, 64'(16 * i + 1), 2'd3, 6'd0);
            step("R7");
        end
        // R9: offers while in_ready is low must leave no trace
        for (int i = 0; i < 3; i++) begin
            put(0, 2'd2, 64'hFFFF_0000, 2'd1, 6'd7); put(1, 2'd0, 64'h77, 2'd1, 6'd0);
            step("R9");
        end
        repeat (10) step("");

        // random phase: mixed kinds, narrow and wide values, few PC indices
        for (int n = 0; n < 4000; n++) begin
            for (int j = 0; j < 2; j++) begin
                if ($urandom_range(0, 99) < 70) begin
                    logic [63:0] d = {$urandom, $urandom};
                    if ($urandom_range(0, 1) == 0) d = d & 64'h3FF;
                    put(j, 2'($urandom_range(0, 3)), d, 2'($urandom_range(0, 3)),
                        6'($urandom_range(0, 3)));
                end
            end
            step("");
        end
        repeat (12) step("");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule